// File: doc/BRIEF.md
# Scan-Aware Clock Rate Steering

This block spreads one fast reference clock over several clock domains. It does this by producing clock-enable pulses instead of gated clocks. There are three paths:

- A programmable path that runs at full rate or at one quarter rate.
- A fixed half-rate path.
- A selector that gives a third domain either a slow eighth-rate source or the half-rate path.

In functional operation, software-owned control inputs choose the programmable ratio and the selector path. When scan mode is raised for at-speed test, the block ignores those controls. The programmable path goes to full rate, the half-rate divider keeps running, and the selector moves to the half-rate path, which is the fastest rate it can offer. Each divider also drives a flag that tells the test insertion flow whether its counter state must stay out of the scan chains. The fixed divider is always excluded. The programmable divider is excluded only in functional operation, because in bypass its state has no effect on its output.

A new ratio or path choice is applied only at a period boundary, so the output never shows a shortened or doubled period. This includes the change caused by entering or leaving scan mode. For the programmable path the boundary is its own enable pulse. For the selector it is a cycle in which both of its sources pulse together.

Top module: `scan_clk_steer`

## Requirements
- R1: With `prog_ratio_sel_i` = 0 and scan off, `prog_ce_o` is high every cycle (divide by 1). With `prog_ratio_sel_i` = 1 it is high one cycle in four (divide by 4).
- R2: While `scan_mode_i` is high, `prog_ratio_sel_i` is ignored and `prog_ce_o` is high every cycle once the current period has ended.
- R3: `half_ce_o` is high exactly every second cycle in both functional and scan operation. It is low in the first cycle after reset.
- R4: With `mux_sel_i` = 0 and scan off, `mux_ce_o` follows the eighth-rate source (one pulse in eight cycles). With `mux_sel_i` = 1 it follows the half-rate path.
- R5: While `scan_mode_i` is high, `mux_sel_i` is ignored and `mux_ce_o` follows the half-rate path.
- R6: A change of ratio or path, including scan entry and exit, takes effect only at a boundary. After the last pulse at the old setting, the next pulse comes one full old period later.
- R7: `half_scan_excl_o` is always high. `prog_scan_excl_o` is high exactly when `scan_mode_i` is low.
- R8: A synchronous active-high `rst_i` clears all counters and selects ratio 1 and selector input 0. In the cycle after a reset edge, `prog_ce_o` is high and `half_ce_o` and `mux_ce_o` are low.
- R9: The slow source behind selector input 0 pulses once every eight reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scan_mode_i | input | 1 | At-speed test mode; overrides the functional controls |
| prog_ratio_sel_i | input | 1 | Programmable ratio: 0 = divide by 1, 1 = divide by 4 |
| mux_sel_i | input | 1 | Selector path: 0 = eighth-rate source, 1 = half-rate path |
| prog_ce_o | output | 1 | Enable pulse of the programmable path |
| half_ce_o | output | 1 | Enable pulse of the fixed half-rate path |
| mux_ce_o | output | 1 | Enable pulse of the selector output |
| prog_scan_excl_o | output | 1 | Keep the programmable divider state out of scan |
| half_scan_excl_o | output | 1 | Keep the fixed divider state out of scan |

## Verification
The assertions assume two things about the inputs and the parameters:
- Every requested ratio lies between 1 and the divider's maximum.
- Each pulse of the slow source falls on a pulse of the half-rate path, since both counters leave reset together and the slow ratio is a multiple of two.

The stimulus changes controls only at the falling edge. It lets every setting run past at least one full slow period before it opens a pulse-counting window. The windows are 64 cycles long, a multiple of every ratio, so each count is exact whatever the starting phase.

// File: rtl/scan_clk_pkg.sv
package scan_clk_pkg;

   typedef enum logic {
      PROG_FULL    = 1'b0,
      PROG_QUARTER = 1'b1
   } prog_ratio_e;

   typedef enum logic {
      PATH_SLOW = 1'b0,
      PATH_HALF = 1'b1
   } path_sel_e;

endpackage

// File: rtl/ce_divider.sv
module ce_divider #(
   parameter int unsigned MAX_RATIO = 4,
   parameter int unsigned RST_RATIO = 1,
   localparam int unsigned RW = $clog2(MAX_RATIO + 1),
   localparam int unsigned CW = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [RW-1:0] ratio_i,
   output logic          ce_o
);

   if (MAX_RATIO < 1) begin : g_bad_max
      $error("ce_divider: MAX_RATIO must be at least 1");
   end
   if (RST_RATIO < 1 || RST_RATIO > MAX_RATIO) begin : g_bad_rst
      $error("ce_divider: RST_RATIO out of range");
   end

   if (MAX_RATIO == 1) begin : g_passthru
      logic unused_ratio;
      assign unused_ratio = ^ratio_i;
      assign ce_o = 1'b1;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      logic [RW-1:0] ratio_q;
      logic [RW-1:0] last_w;

      assign last_w = ratio_q - RW'(1);
      assign ce_o   = (RW'(cnt_q) == last_w);

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            cnt_q   <= '0;
            ratio_q <= RW'(RST_RATIO);
         end else if (ce_o) begin
            cnt_q   <= '0;
            ratio_q <= ratio_i;
         end else begin
            cnt_q   <= cnt_q + CW'(1);
         end
      end

      AST_RATIO_REQ_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
         (ratio_i >= RW'(1)) && (ratio_i <= RW'(MAX_RATIO))); // R1
      AST_CNT_BELOW_RATIO: assert property (@(posedge clk_i) disable iff (rst_i)
         RW'(cnt_q) < ratio_q); // R1
      AST_RATIO_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
         !ce_o |=> $stable(ratio_q)); // R6
   end

endmodule

// File: rtl/ce_path_mux.sv
module ce_path_mux
   import scan_clk_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic slow_ce_i,
   input  logic half_ce_i,
   input  logic sel_i,
   output logic ce_o
);

   path_sel_e sel_q;
   logic      common_edge;

   assign common_edge = slow_ce_i & half_ce_i;
   assign ce_o        = (sel_q == PATH_HALF) ? half_ce_i : slow_ce_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q <= PATH_SLOW;
      end else if (common_edge) begin
         sel_q <= path_sel_e'(sel_i);
      end
   end

   AST_SLOW_ON_HALF_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
      slow_ce_i |-> half_ce_i); // R6
   AST_SEL_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
      !common_edge |=> $stable(sel_q)); // R6

endmodule

// File: rtl/scan_clk_steer.sv
module scan_clk_steer
   import scan_clk_pkg::*;
#(
   parameter int unsigned PROG_RATIO = 4,
   parameter int unsigned HALF_RATIO = 2,
   parameter int unsigned SLOW_RATIO = 8,
   localparam int unsigned PRW = $clog2(PROG_RATIO + 1),
   localparam int unsigned HRW = $clog2(HALF_RATIO + 1),
   localparam int unsigned SRW = $clog2(SLOW_RATIO + 1)
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic scan_mode_i,
   input  logic prog_ratio_sel_i,
   input  logic mux_sel_i,
   output logic prog_ce_o,
   output logic half_ce_o,
   output logic mux_ce_o,
   output logic prog_scan_excl_o,
   output logic half_scan_excl_o
);

   if (PROG_RATIO < 2) begin : g_bad_prog
      $error("scan_clk_steer: PROG_RATIO must be at least 2");
   end
   if (HALF_RATIO < 2 || SLOW_RATIO <= HALF_RATIO) begin : g_bad_order
      $error("scan_clk_steer: need 2 <= HALF_RATIO < SLOW_RATIO");
   end
   if ((SLOW_RATIO % HALF_RATIO) != 0) begin : g_bad_align
      $error("scan_clk_steer: SLOW_RATIO must be a multiple of HALF_RATIO");
   end

   logic [PRW-1:0] prog_req;
   logic           path_req;
   logic           slow_ce;

   // scan override: force bypass of programmable divider, fastest mux path
   assign prog_req = (scan_mode_i || prog_ratio_sel_i == PROG_FULL) ? PRW'(1)
                                                                     : PRW'(PROG_RATIO);
   assign path_req = scan_mode_i ? PATH_HALF : mux_sel_i;

   assign prog_scan_excl_o = ~scan_mode_i;
   assign half_scan_excl_o = 1'b1;

   ce_divider #(.MAX_RATIO(PROG_RATIO), .RST_RATIO(1)) u_prog_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ratio_i (prog_req),
      .ce_o    (prog_ce_o)
   );

   ce_divider #(.MAX_RATIO(HALF_RATIO), .RST_RATIO(HALF_RATIO)) u_half_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ratio_i (HRW'(HALF_RATIO)),
      .ce_o    (half_ce_o)
   );

   ce_divider #(.MAX_RATIO(SLOW_RATIO), .RST_RATIO(SLOW_RATIO)) u_slow_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ratio_i (SRW'(SLOW_RATIO)),
      .ce_o    (slow_ce)
   );

   ce_path_mux u_path_mux (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .slow_ce_i (slow_ce),
      .half_ce_i (half_ce_o),
      .sel_i     (path_req),
      .ce_o      (mux_ce_o)
   );

   AST_RESET_STATE: assert property (@(posedge clk_i)
      rst_i |=> (prog_ce_o && !half_ce_o && !mux_ce_o)); // R8
   AST_SCAN_PROG_FULL_RATE: assert property (@(posedge clk_i) disable iff (rst_i)
      (scan_mode_i && prog_ce_o) |=> prog_ce_o); // R2
   AST_SCAN_MUX_FAST: assert property (@(posedge clk_i) disable iff (rst_i)
      (scan_mode_i && slow_ce) |=> (mux_ce_o == half_ce_o)); // R5

   if (HALF_RATIO == 2) begin : g_half_chk
      AST_HALF_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
         half_ce_o |=> !half_ce_o); // R3
      AST_HALF_RISES: assert property (@(posedge clk_i) disable iff (rst_i)
         !half_ce_o |=> half_ce_o); // R3
   end

endmodule

// File: tb/scan_clk_steer_bench.sv
module scan_clk_steer_bench;

   logic clk = 1'b0;
   logic rst_i;
   logic scan_mode_i;
   logic prog_ratio_sel_i;
   logic mux_sel_i;
   logic prog_ce_o, half_ce_o, mux_ce_o;
   logic prog_scan_excl_o, half_scan_excl_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   scan_clk_steer u_scan_clk_steer (
      .clk_i            (clk),
      .rst_i            (rst_i),
      .scan_mode_i      (scan_mode_i),
      .prog_ratio_sel_i (prog_ratio_sel_i),
      .mux_sel_i        (mux_sel_i),
      .prog_ce_o        (prog_ce_o),
      .half_ce_o        (half_ce_o),
      .mux_ce_o         (mux_ce_o),
      .prog_scan_excl_o (prog_scan_excl_o),
      .half_scan_excl_o (half_scan_excl_o)
   );

   typedef struct {
      int    prog;
      int    half;
      int    mux;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   event go_ev;
   event done_ev;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: counts pulses over a 64-cycle window and compares with scoreboard
   initial begin
      forever begin
         int cp, ch, cm;
         exp_t e;
         @(go_ev);
         cp = 0; ch = 0; cm = 0;
         repeat (64) begin
            @(negedge clk);
            if (prog_ce_o) cp++;
            if (half_ce_o) ch++;
            if (mux_ce_o)  cm++;
         end
         e = sb_q.pop_front();
         check({e.tag, " programmable count"}, cp, e.prog);
         check({"R3 half count in ", e.tag}, ch, e.half);
         check({e.tag, " selector count"}, cm, e.mux);
         ->done_ev;
      end
   end

   // driver: applies a setting, lets it settle, pushes the expected counts
   task automatic run_window(input logic scan, input logic rsel, input logic msel,
                             input int ep, input int eh, input int em, input string tag);
      exp_t e;
      @(negedge clk);
      scan_mode_i      = scan;
      prog_ratio_sel_i = rsel;
      mux_sel_i        = msel;
      repeat (24) @(negedge clk);
      e.prog = ep; e.half = eh; e.mux = em; e.tag = tag;
      sb_q.push_back(e);
      ->go_ev;
      @(done_ev);
      check("R7 prog exclude flag", int'(prog_scan_excl_o), int'(!scan));
      check("R7 half exclude flag", int'(half_scan_excl_o), 1);
   endtask

   task automatic wait_prog_pulse();
      do @(negedge clk); while (!prog_ce_o);
   endtask

   task automatic wait_mux_pulse();
      do @(negedge clk); while (!mux_ce_o);
   endtask

   initial begin
      int n;
      rst_i            = 1'b1;
      scan_mode_i      = 1'b0;
      prog_ratio_sel_i = 1'b0;
      mux_sel_i        = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 reset prog_ce", int'(prog_ce_o), 1);
      check("R8 reset half_ce", int'(half_ce_o), 0);
      check("R8 reset mux_ce",  int'(mux_ce_o),  0);
      rst_i = 1'b0;

      run_window(1'b0, 1'b0, 1'b0, 64, 32, 8,  "R1 R4 R9 func div1 slow");
      run_window(1'b0, 1'b1, 1'b1, 16, 32, 32, "R1 R4 func div4 half");
      run_window(1'b1, 1'b1, 1'b0, 64, 32, 32, "R2 R5 scan override");
      run_window(1'b0, 1'b1, 1'b0, 16, 32, 8,  "R6 scan exit func div4 slow");

      // R6: ratio change from 4 to 1 waits for the period to end
      wait_prog_pulse();
      @(negedge clk);
      prog_ratio_sel_i = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!prog_ce_o);
      check("R6 prog gap after ratio change", n, 3);
      @(negedge clk);
      check("R1 prog full rate after change", int'(prog_ce_o), 1);

      // R2: scan entry during a quarter-rate period
      prog_ratio_sel_i = 1'b1;
      repeat (8) @(negedge clk);
      wait_prog_pulse();
      @(negedge clk);
      scan_mode_i = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!prog_ce_o);
      check("R2 prog gap at scan entry", n, 3);
      @(negedge clk);
      check("R2 prog full rate in scan", int'(prog_ce_o), 1);
      scan_mode_i = 1'b0;
      mux_sel_i   = 1'b0;
      repeat (16) @(negedge clk);

      // R6: selector switch from slow to half path
      wait_mux_pulse();
      @(negedge clk);
      mux_sel_i = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!mux_ce_o);
      check("R6 mux gap at switch", n, 7);
      n = 0;
      do begin @(negedge clk); n++; end while (!mux_ce_o);
      check("R4 mux gap on half path", n, 2);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule